// File: doc/BRIEF.md
# Staged FPGA Rail Power Sequencer

This controller powers an FPGA's supply rails up and down in a fixed, branching order. A single master enable starts the sequence. The 1.0 V core rail and the 5.0 V boost rail switch on together. The 1.8 V auxiliary rail waits until the core rail is stable, and the gated 3.3 V I/O rail waits until the auxiliary rail is stable. The controller declares itself ready only when the I/O rail and the boost rail are both stable. At that point it drives the cartridge supply select, which picks 5.0 V (taken from the boost rail) or 3.3 V (taken from the gated I/O rail) according to the cartridge type latched on entry to ready.

Each power-good input passes through a two-stage synchronizer. It counts as stable only after `STABLE_CYC` consecutive high samples. If an awaited rail does not become stable within `TIMEOUT_CYC` cycles, every enable is dropped and a fault is held until the master enable goes low. When the master enable falls, the rails are unwound in reverse order, one step per clock.

Top module: `fpga_rail_seq`

## Requirements
- R1: During and right after reset, all rail enables, `ready`, `fault` and `cart_sel_5v` are 0.
- R2: One clock after `master_en` is sampled high in the off state, `en_core` and `en_boost` rise together, while `en_aux` and `en_io` stay 0.
- R3: `pg[i]` is synchronized by two flops. It counts as stable once the synchronized value has been high for `STABLE_CYC` consecutive cycles, and any low sample restarts the count.
- R4: `en_aux` rises only on the clock after the core rail (`pg[0]`) is stable.
- R5: `en_io` rises only on the clock after the auxiliary rail (`pg[2]`) is stable.
- R6: `ready` rises on the clock after both the I/O rail (`pg[3]`) and the boost rail (`pg[1]`) are stable while `en_io` is on.
- R7: `cart_sel_5v` is 1 (5.0 V) only while `ready` is high and the latched cartridge type is 1 (5 V cartridge). Otherwise it is 0 (3.3 V).
- R8: If an awaited rail is not stable after `TIMEOUT_CYC` cycles in its wait step, all enables and `ready` drop and `fault` goes high. `fault` holds until `master_en` is sampled low, and clears on the next clock.
- R9: When `master_en` falls in the ready state, the controller takes one clock per step: first `ready` and the cartridge select drop, then `en_io`, then `en_aux`, then `en_core` and `en_boost` together.
- R10: When `master_en` falls during a wait step, unwinding starts at that step: `en_io`, then `en_aux`, then core and boost. Rails that were never enabled are skipped.
- R11: The cartridge type (`cart_is_5v`, two-flop synchronized) is latched on entry to ready. Changes to it while ready have no effect on `cart_sel_5v`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Request to power the FPGA rails |
| pg | input | 4 | Power-good flags: bit0 1.0 V, bit1 5.0 V, bit2 1.8 V, bit3 3.3 V I/O |
| cart_is_5v | input | 1 | Cartridge type: 1 = 5 V type, 0 = 3.3 V type |
| en_core | output | 1 | 1.0 V core rail enable |
| en_boost | output | 1 | 5.0 V boost rail enable |
| en_aux | output | 1 | 1.8 V rail enable |
| en_io | output | 1 | Gated 3.3 V I/O rail enable |
| cart_sel_5v | output | 1 | Cartridge supply select: 1 = 5.0 V, 0 = 3.3 V |
| ready | output | 1 | Whole chain up, cartridge supply active |
| fault | output | 1 | Power-good timeout seen, sequence halted |

## Verification
The bench builds the block with `STABLE_CYC=3` and `TIMEOUT_CYC=16`. A simulated plant raises each power-good 0 to 8 cycles after its enable, so with these values a normal bring-up finishes well inside the window. Rails that never come up and one-cycle power-good glitches then push the sequencer into the timeout fault within a few dozen cycles. The short windows also let random master-enable toggles hit every wait step and every unwind step many times, along with cartridge-type changes before and during ready.

// File: rtl/fpga_rail_seq.sv
module fpga_rail_seq #(
  parameter int STABLE_CYC  = 16,
  parameter int TIMEOUT_CYC = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       master_en,
  input  logic [3:0] pg,
  input  logic       cart_is_5v,
  output logic       en_core,
  output logic       en_boost,
  output logic       en_aux,
  output logic       en_io,
  output logic       cart_sel_5v,
  output logic       ready,
  output logic       fault
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam int TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;

  typedef enum logic [3:0] {
    S_OFF, S_CORE, S_AUX, S_IO, S_READY, S_DN_CART, S_DN_IO, S_DN_AUX, S_FAULT
  } st_t;

  st_t st, nxt;
  logic [3:0]    pg_s1, pg_s2, stable;
  logic [SW-1:0] cnt [4];
  logic [TW-1:0] tmo;
  logic          cart_s1, cart_s2, cart_q;
  wire           tmo_hit = (tmo == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pg_s1 <= '0; pg_s2 <= '0; cart_s1 <= 1'b0; cart_s2 <= 1'b0;
      for (int i = 0; i < 4; i++) cnt[i] <= '0;
    end else begin
      pg_s1 <= pg; pg_s2 <= pg_s1;
      cart_s1 <= cart_is_5v; cart_s2 <= cart_s1;
      for (int i = 0; i < 4; i++)
        if (!pg_s2[i]) cnt[i] <= '0;
        else if (cnt[i] != SW'(STABLE_CYC)) cnt[i] <= cnt[i] + 1'b1;
    end

  always_comb
    for (int i = 0; i < 4; i++) stable[i] = (cnt[i] == SW'(STABLE_CYC));

  always_comb begin
    nxt = st;
    case (st)
      S_OFF:     if (master_en) nxt = S_CORE;
      S_CORE:    if (!master_en) nxt = S_OFF;
                 else if (stable[0]) nxt = S_AUX;
                 else if (tmo_hit) nxt = S_FAULT;
      S_AUX:     if (!master_en) nxt = S_DN_AUX;
                 else if (stable[2]) nxt = S_IO;
                 else if (tmo_hit) nxt = S_FAULT;
      S_IO:      if (!master_en) nxt = S_DN_IO;
                 else if (stable[3] && stable[1]) nxt = S_READY;
                 else if (tmo_hit) nxt = S_FAULT;
      S_READY:   if (!master_en) nxt = S_DN_CART;
      S_DN_CART: nxt = S_DN_IO;
      S_DN_IO:   nxt = S_DN_AUX;
      S_DN_AUX:  nxt = S_OFF;
      S_FAULT:   if (!master_en) nxt = S_OFF;
      default:   nxt = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_OFF; tmo <= '0; cart_q <= 1'b0;
    end else begin
      st  <= nxt;
      tmo <= (nxt != st) ? '0 : (tmo_hit ? tmo : tmo + 1'b1);
      if (st == S_IO && nxt == S_READY) cart_q <= cart_s2;
    end

  assign en_core  = st inside {S_CORE, S_AUX, S_IO, S_READY, S_DN_CART, S_DN_IO, S_DN_AUX};
  assign en_boost = en_core;
  assign en_aux   = st inside {S_AUX, S_IO, S_READY, S_DN_CART, S_DN_IO};
  assign en_io    = st inside {S_IO, S_READY, S_DN_CART};
  assign ready    = (st == S_READY);
  assign cart_sel_5v = ready & cart_q;
  assign fault    = (st == S_FAULT);
endmodule

// File: rtl/fpga_rail_seq_chk.sv
module fpga_rail_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       master_en,
  input logic [3:0] pg,
  input logic       cart_is_5v,
  input logic       en_core,
  input logic       en_boost,
  input logic       en_aux,
  input logic       en_io,
  input logic       cart_sel_5v,
  input logic       ready,
  input logic       fault
);
  assert_core_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_core) |-> (en_boost && !en_aux && !en_io));
  assert_aux_after_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_aux) |-> $past(en_core));
  assert_io_after_aux_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_io) |-> $past(en_aux));
  assert_sel_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cart_sel_5v |-> ready);
  assert_fault_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(en_core || en_boost || en_aux || en_io || ready));
  assert_io_down_after_cart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_io) && !fault) |-> $past(!ready));
  assert_aux_down_after_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_aux) && !fault) |-> $past(!en_io));
  assert_core_down_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en_core) && !fault) |-> $past(!en_aux));
  assert_sel_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(cart_sel_5v));
endmodule

bind fpga_rail_seq fpga_rail_seq_chk chk_i (.*);

// File: tb/fpga_rail_seq_tb.sv
module fpga_rail_seq_tb_top;
  localparam int ST = 3;
  localparam int TO = 16;

  logic clk = 1'b0, rst_n = 1'b0, master_en = 1'b0, cart_is_5v = 1'b0;
  logic [3:0] pg = '0;
  logic en_core, en_boost, en_aux, en_io, cart_sel_5v, ready, fault;

  fpga_rail_seq #(.STABLE_CYC(ST), .TIMEOUT_CYC(TO)) dut_i (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  int saw_ready = 0, saw_fault = 0, saw_sel5 = 0;

  // Reference model states: 0 off,1 core,2 aux,3 io,4 ready,5 dn_cart,6 dn_io,7 dn_aux,8 fault
  int m_st = 0, m_tmo = 0, m_cnt[4];
  logic [3:0] m_s1 = '0, m_s2 = '0;
  logic m_c1 = 0, m_c2 = 0, m_cart = 0;

  function automatic bit f_core(int s); return s >= 1 && s <= 7; endfunction
  function automatic bit f_aux(int s);  return s >= 2 && s <= 6; endfunction
  function automatic bit f_io(int s);   return s >= 3 && s <= 5; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_tmo = 0; m_s1 = '0; m_s2 = '0; m_c1 = 0; m_c2 = 0; m_cart = 0;
      for (int i = 0; i < 4; i++) m_cnt[i] = 0;
    end else begin
      bit [3:0] stb;
      int n;
      for (int i = 0; i < 4; i++) stb[i] = (m_cnt[i] == ST);   // R3 stability filter
      n = m_st;
      case (m_st)
        0: if (master_en) n = 1;
        1: n = !master_en ? 0 : stb[0] ? 2 : (m_tmo == TO-1) ? 8 : 1;
        2: n = !master_en ? 7 : stb[2] ? 3 : (m_tmo == TO-1) ? 8 : 2;  // R10 unwind
        3: n = !master_en ? 6 : (stb[3] && stb[1]) ? 4 : (m_tmo == TO-1) ? 8 : 3;
        4: if (!master_en) n = 5;                                      // R9 unwind
        5: n = 6;
        6: n = 7;
        7: n = 0;
        8: if (!master_en) n = 0;
        default: n = 0;
      endcase
      if (n != m_st) m_tmo = 0; else if (m_tmo != TO-1) m_tmo++;
      if (m_st == 3 && n == 4) m_cart = m_c2;                          // R11 latch
      for (int i = 0; i < 4; i++) m_cnt[i] = !m_s2[i] ? 0 : (m_cnt[i] == ST ? ST : m_cnt[i] + 1);
      m_s2 = m_s1; m_s1 = pg; m_c2 = m_c1; m_c1 = cart_is_5v;
      m_st = n;
    end
  end

  task automatic chk(string req, string nm, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, nm, cyc, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R2 R10", "en_core",  en_core,  f_core(m_st));
    chk("R2 R9",  "en_boost", en_boost, f_core(m_st));
    chk("R3 R4 R9", "en_aux", en_aux,   f_aux(m_st));
    chk("R5 R9 R10", "en_io", en_io,    f_io(m_st));
    chk("R6", "ready", ready, m_st == 4);
    chk("R7 R11", "cart_sel_5v", cart_sel_5v, (m_st == 4) && m_cart);
    chk("R8", "fault", fault, m_st == 8);
    if (ready) saw_ready++;
    if (fault) saw_fault++;
    if (cart_sel_5v) saw_sel5++;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int dly[4], hold = 0;
  bit dead[4], prev_en[4];

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) begin dly[i] = 0; dead[i] = 0; prev_en[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "en_core",  en_core,  1'b0);
    chk("R1", "en_aux",   en_aux,   1'b0);
    chk("R1", "en_io",    en_io,    1'b0);
    chk("R1", "ready",    ready,    1'b0);
    chk("R1", "fault",    fault,    1'b0);
    chk("R1", "cart_sel_5v", cart_sel_5v, 1'b0);
    rst_n = 1'b1;
    // Directed: 5 V cartridge, all rails respond promptly
    cart_is_5v = 1'b1; master_en = 1'b1; hold = 200;
    for (int k = 0; k < 30000; k++) begin
      @(negedge clk);
      check_all();
      if (k >= 2000) begin
        if (hold == 0) begin master_en = ~master_en; hold = 20 + ($urandom % 280); end
        else hold--;
        if ($urandom % 50 == 0) cart_is_5v = ~cart_is_5v;
      end else if (hold == 0) begin
        master_en = ~master_en; hold = 200;
      end else hold--;
      begin
        logic [3:0] en_v;
        en_v = {en_io, en_aux, en_boost, en_core};
        for (int i = 0; i < 4; i++) begin
          if (!en_v[i]) begin pg[i] = 1'b0; prev_en[i] = 0; end
          else begin
            if (!prev_en[i]) begin
              dly[i] = $urandom % 9;
              dead[i] = (k >= 2000) && ($urandom % 16 == 0);
              prev_en[i] = 1;
            end
            if (dly[i] > 0) begin dly[i]--; pg[i] = 1'b0; end
            else pg[i] = !dead[i] && !((k >= 2000) && ($urandom % 40 == 0));
          end
        end
      end
    end
    tests++; if (saw_ready == 0) begin fails++; $display("FAIL R6 ready never seen: actual 0 expected >0"); end
    tests++; if (saw_fault == 0) begin fails++; $display("FAIL R8 fault never seen: actual 0 expected >0"); end
    tests++; if (saw_sel5 == 0)  begin fails++; $display("FAIL R7 5V select never seen: actual 0 expected >0"); end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule